// File: doc/BRIEF.md
# Eight-Stage Pseudo-Random Bit Generator with Zero-Lock Recovery

The block is an 8-stage Fibonacci linear feedback shift register. On every enabled rising clock edge all stages move one place towards the serial end, and the first stage takes the XOR of four tapped stages. The tap set gives a maximal-length sequence: 255 distinct nonzero states per period. The serial bit and the full 8-bit state are both outputs.

Reset clears every stage to zero. That is the one state the XOR feedback can never leave. A zero-run watchdog watches the serial output instead of a seed. It counts enabled edges on which the serial bit is low and clears on any high bit. Once the count reaches a timeout, the next enabled edge forces a 1 into stage 1, and the sequence then runs by itself. The timeout must exceed 7, the longest run of zeros a running sequence can show, so the watchdog never disturbs normal operation.

Top module: `lfsr8_gen`

## Requirements
- R1: While rst_ni is low, and right after it is released, state_o is 8'h00 and serial_o is 0.
- R2: On each rising clk_i edge with en_i high, state_o[7:1] takes the old state_o[6:0] and state_o[0] takes the new input bit. serial_o always equals state_o[7], which is stage 8.
- R3: Outside recovery, the new bit for state_o[0] is state_o[7] ^ state_o[5] ^ state_o[4] ^ state_o[3], the XOR of stages 8, 6, 5 and 4.
- R4: Starting from state 8'h01, the state returns to 8'h01 after exactly 255 enabled edges. Each of the 255 nonzero values appears exactly once in that period.
- R5: The watchdog counts enabled edges on which serial_o is 0 and clears when serial_o is 1. After reset with en_i held high, the state stays 8'h00 for the first TIMEOUT (16) edges and becomes 8'h01 on edge TIMEOUT+1.
- R6: Once the state is nonzero, it never returns to zero, and the watchdog never alters the feedback bit.
- R7: On an edge with en_i low, both the state and the watchdog count hold. Zero-run edges counted before a pause and after it add up to the timeout.
- R8: If the timeout has been reached while en_i is low, the forced 1 does not enter. It enters on the first edge with en_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for both the shift and the watchdog |
| serial_o | output | 1 | Serial output bit (stage 8) |
| state_o | output | 8 | All eight stages, bit 0 is stage 1 |

## Verification
Two things can fall on the same edge: the watchdog's forced injection and a low clock enable. To provoke this, the bench runs the counter to exactly the timeout after reset, then holds en_i low for several cycles. It judges the result by checking that the state stays 8'h00 throughout the pause and becomes 8'h01 on the first enabled edge after it. A second case pauses the counter part-way, to show that zero-run edges before and after a pause add up to the timeout.

// File: rtl/lfsr8_pkg.sv
package lfsr8_pkg;
  localparam int unsigned DEF_WIDTH   = 8;
  // stages 8,6,5,4 -> bits 7,5,4,3
  localparam logic [7:0]  DEF_TAPS    = 8'hB8;
  localparam int unsigned DEF_TIMEOUT = 16;
endpackage

// File: rtl/lfsr_shift.sv
module lfsr_shift #(
  parameter int unsigned     WIDTH = lfsr8_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS = lfsr8_pkg::DEF_TAPS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             inject_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] tap_bits;
  logic             fb;

  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign tap_bits[i] = state_q[i];
    end else begin : g_off
      assign tap_bits[i] = 1'b0;
    end
  end

  assign fb = ^tap_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= '0;
    else if (en_i) state_q <= {state_q[WIDTH-2:0], fb | inject_i};
  end

  assign state_o = state_q;

  // R2
  shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0]));
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_q));
endmodule

// File: rtl/zero_watchdog.sv
module zero_watchdog #(
  parameter int unsigned TIMEOUT = lfsr8_pkg::DEF_TIMEOUT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic serial_i,
  output logic force_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q;

  assign force_o = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (en_i) begin
      if (serial_i || force_o) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/lfsr8_gen.sv
module lfsr8_gen #(
  parameter int unsigned WIDTH   = lfsr8_pkg::DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS = lfsr8_pkg::DEF_TAPS,
  parameter int unsigned TIMEOUT = lfsr8_pkg::DEF_TIMEOUT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic             serial_o,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state;
  logic             force_one;

  lfsr_shift #(.WIDTH(WIDTH), .TAPS(TAPS)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .inject_i (force_one),
    .state_o  (state)
  );

  zero_watchdog #(.TIMEOUT(TIMEOUT)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .serial_i (state[WIDTH-1]),
    .force_o  (force_one)
  );

  assign state_o  = state;
  assign serial_o = state[WIDTH-1];

  // R6
  no_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state != '0) |=> state != '0);
  // R6
  force_zero_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_one |-> state == '0);
endmodule

// File: tb/lfsr8_gen_tb.sv
module lfsr8_gen_tb;
  localparam int TIMEOUT = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       serial_o;
  logic [7:0] state_o;

  int total = 0;
  int bad = 0;
  int m_st = 0;
  int m_zrun = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lfsr8_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .serial_o(serial_o), .state_o(state_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: zero-run length and the shifting word as integers
  task automatic model_edge(input bit en);
    int sout, nb;
    if (!en) return;
    sout = (m_st >> 7) & 1;
    if (m_zrun >= TIMEOUT) begin
      nb = 1;
      m_zrun = 0;
    end else begin
      nb = ((m_st >> 7) ^ (m_st >> 5) ^ (m_st >> 4) ^ (m_st >> 3)) & 1;
      if (sout == 1) m_zrun = 0; else m_zrun = m_zrun + 1;
    end
    m_st = ((m_st << 1) | nb) & 8'hFF;
  endtask

  task automatic step(input bit en);
    int prev;
    @(negedge clk_i);
    en_i = en;
    prev = state_o;
    @(posedge clk_i);
    model_edge(en);
    #1;
    chk(state_o == m_st[7:0], "R2/R3 state", state_o, m_st);
    chk(serial_o == state_o[7], "R2 serial", serial_o, state_o[7]);
    if (!en) chk(state_o == prev[7:0], "R7 hold", state_o, prev);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    en_i = 1'b0;
    m_st = 0;
    m_zrun = 0;
    @(negedge clk_i);
    chk(state_o == 8'h00 && serial_o == 1'b0, "R1 in reset", state_o, 0);
    rst_ni = 1'b1;
    #1;
    chk(state_o == 8'h00, "R1 after release", state_o, 0);
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog timeout", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int seen [256];
    bit ok;
    do_reset();

    // R5: recovery edge from reset
    n = 0;
    do begin step(1'b1); n++; end while (state_o == 8'h00 && n < 100);
    chk(n == TIMEOUT + 1, "R5 recovery edge", n, TIMEOUT + 1);
    chk(state_o == 8'h01, "R5 first state", state_o, 1);

    // R4 / R6: one full period
    foreach (seen[i]) seen[i] = 0;
    for (int i = 0; i < 255; i++) begin
      seen[state_o]++;
      step(1'b1);
      chk(state_o != 8'h00, "R6 nonzero", state_o, 1);
    end
    chk(state_o == 8'h01, "R4 period 255", state_o, 1);
    ok = (seen[0] == 0);
    for (int i = 1; i < 256; i++) if (seen[i] != 1) ok = 1'b0;
    chk(ok, "R4 each state once", seen[0], 0);

    // R7: random enable pattern against the model
    for (int i = 0; i < 400; i++) step(bit'($urandom_range(0, 1)));
    chk(state_o != 8'h00, "R6 still running", state_o, 1);

    // R8: timeout reached while enable low
    do_reset();
    for (int i = 0; i < TIMEOUT; i++) step(1'b1);
    chk(state_o == 8'h00, "R8 at timeout", state_o, 0);
    for (int i = 0; i < 6; i++) step(1'b0);
    chk(state_o == 8'h00, "R8 no inject while disabled", state_o, 0);
    step(1'b1);
    chk(state_o == 8'h01, "R8 inject on enable", state_o, 1);

    // R7: count held across a pause
    do_reset();
    for (int i = 0; i < 10; i++) step(1'b1);
    for (int i = 0; i < 4; i++) step(1'b0);
    n = 0;
    do begin step(1'b1); n++; end while (state_o == 8'h00 && n < 100);
    chk(n == TIMEOUT + 1 - 10, "R7 count resumes", n, TIMEOUT + 1 - 10);

    // R5: reset mid-run clears count; restart timing identical
    for (int i = 0; i < 37; i++) step(1'b1);
    do_reset();
    n = 0;
    do begin step(1'b1); n++; end while (state_o == 8'h00 && n < 100);
    chk(n == TIMEOUT + 1, "R5 recovery after rerun", n, TIMEOUT + 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule